// File: doc/BRIEF.md
# Boundary-Scan Signature and Pattern Engine

This block holds two 8-bit test registers that sit in a boundary-scan path and run on the test clock `tck`. The input-side register compacts the values on the input pins into a parallel signature. The output-side register produces a stimulus sequence at the same time. Each register has a shadow stage. The input shadow feeds the core logic, and the output shadow drives the device output pins. Both shadows take their new value on the falling edge of `tck` that follows a test step.

The `mode` input selects what the output side does. It either advances a maximal-length linear-feedback sequence or counts up in binary. In both modes the input side compacts in the same way. Before a run, both registers are seeded through one 16-bit serial chain that goes from `tdi` to `tdo`. The same chain is used afterwards to read the final signature back out. A scan shift always takes priority over a test step.

Top module: `bsig_engine`

## Requirements
- R1: While `rst_n` is low, both registers and both shadows are 0x00, so `tdo`, `core_out` and `pin_out` are 0.
- R2: While `scan_en` is 1, each rising `tck` edge shifts the 16-bit chain right. `tdi` enters bit 7 of the input register, input bit 0 moves to output bit 7, and `tdo` always shows output bit 0. This happens even when `run_en` is 1, and during the shift neither shadow changes.
- R3: On a rising edge with `run_en`=1 and `scan_en`=0, the input register S becomes {S[6:0], S[7]^S[5]^S[4]^S[3]} XOR `pin_in`. This is polynomial x^8+x^6+x^5+x^4+1 with pin bit i entering stage i.
- R4: `core_out` takes the new input-register value on the falling edge that follows each step.
- R5: With `mode`=0, each step moves the output register P to {P[6:0], P[7]^P[5]^P[4]^P[3]}.
- R6: With `mode`=1, each step adds one to the output register, and 0xFF wraps to 0x00.
- R7: `pin_out` takes the new output-register value on the falling edge that follows each step, and it holds between steps.
- R8: In `mode`=0, an output register seeded with 0x00 stays at 0x00.
- R9: With `run_en`=0 and `scan_en`=0, both registers and both shadows hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_en | input | 1 | Shift the serial chain |
| tdi | input | 1 | Serial data into the chain |
| run_en | input | 1 | Perform a test step |
| mode | input | 1 | Output-side mode: 0 pseudo-random, 1 binary count |
| pin_in | input | 8 | Input pin values to compact |
| tdo | output | 1 | Serial data out of the chain |
| core_out | output | 8 | Input shadow, driven to the core logic |
| pin_out | output | 8 | Output shadow, driven to the output pins |

## Verification
A corrupted signature stage shows on `core_out` at the next falling edge. It also carries forward into every later signature, so the final value read out on `tdo` differs. A wrong pattern or count value reaches `pin_out` half a cycle after the step that produced it. A chain that is misrouted or in the wrong order shows on `tdo` during the read-back of a known seed, at the exact bit position where the error sits. A shadow that loads when it should hold shows up as a changed `core_out` or `pin_out` after an idle period or a scan.

// File: rtl/bsig_pkg.sv
`timescale 1ns/100ps
package bsig_pkg;
  parameter int unsigned SIG_W = 8;
  typedef logic [SIG_W-1:0] sig_t;
  typedef enum logic {GEN_PRPG = 1'b0, GEN_COUNT = 1'b1} gen_mode_e;

  // Fibonacci left shift, feedback from masked taps into bit 0
  function automatic sig_t lfsr_next(input sig_t s, input sig_t taps);
    return {s[SIG_W-2:0], ^(s & taps)};
  endfunction

  function automatic sig_t misr_next(input sig_t s, input sig_t taps, input sig_t d);
    return lfsr_next(s, taps) ^ d;
  endfunction

  function automatic sig_t count_next(input sig_t s);
    return s + sig_t'(1);
  endfunction
endpackage

// File: rtl/bsig_in_side.sv
`timescale 1ns/100ps
module bsig_in_side
  import bsig_pkg::*;
#(
  parameter sig_t TAPS = sig_t'(8'hB8)
) (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_ev,
  input  logic step_ev,
  input  logic ser_in,
  input  sig_t pins,
  output sig_t sig,
  output logic ser_out
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        sig <= '0;
    else if (shift_ev) sig <= {ser_in, sig[SIG_W-1:1]};
    else if (step_ev)  sig <= misr_next(sig, TAPS, pins);
  end

  assign ser_out = sig[0];

  // R9: no event, no change
  a_r9_in_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_ev && !step_ev) |=> $stable(sig));
  // R2: serial entry lands in the top stage
  a_r2_in_entry: assert property (@(posedge tck) disable iff (!rst_n)
    shift_ev |=> sig[SIG_W-1] == $past(ser_in));
endmodule

// File: rtl/bsig_out_side.sv
`timescale 1ns/100ps
module bsig_out_side
  import bsig_pkg::*;
#(
  parameter sig_t TAPS = sig_t'(8'hB8)
) (
  input  logic tck,
  input  logic rst_n,
  input  logic shift_ev,
  input  logic step_ev,
  input  logic mode,
  input  logic ser_in,
  output sig_t pat,
  output logic ser_out
);
  gen_mode_e gmode;
  sig_t      gen_val;

  assign gmode = gen_mode_e'(mode);

  always_comb begin
    unique case (gmode)
      GEN_COUNT: gen_val = count_next(pat);
      default:   gen_val = lfsr_next(pat, TAPS);
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        pat <= '0;
    else if (shift_ev) pat <= {ser_in, pat[SIG_W-1:1]};
    else if (step_ev)  pat <= gen_val;
  end

  assign ser_out = pat[0];

  // R6: count mode wraps 0xFF to 0x00
  a_r6_wrap: assert property (@(posedge tck) disable iff (!rst_n)
    (step_ev && gmode == GEN_COUNT && pat == '1) |=> pat == '0);
  // R8: zero state is a fixed point of the generator
  a_r8_zero_lock: assert property (@(posedge tck) disable iff (!rst_n)
    (step_ev && gmode == GEN_PRPG && pat == '0) |=> pat == '0);
  // R9
  a_r9_out_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (!shift_ev && !step_ev) |=> $stable(pat));
endmodule

// File: rtl/bsig_shadow.sv
`timescale 1ns/100ps
module bsig_shadow
  import bsig_pkg::*;
(
  input  logic tck,
  input  logic rst_n,
  input  logic load,
  input  sig_t d,
  output sig_t q
);
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R4 / R7: a load on the falling edge captures the stage value
  a_r7_shadow_load: assert property (@(negedge tck) disable iff (!rst_n)
    load |=> q == $past(d));
  a_r7_shadow_hold: assert property (@(negedge tck) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/bsig_engine.sv
`timescale 1ns/100ps
module bsig_engine
  import bsig_pkg::*;
#(
  parameter sig_t TAPS = sig_t'(8'hB8)
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             tdi,
  input  logic             run_en,
  input  logic             mode,
  input  logic [SIG_W-1:0] pin_in,
  output logic             tdo,
  output logic [SIG_W-1:0] core_out,
  output logic [SIG_W-1:0] pin_out
);
  logic shift_ev, step_ev, step_q, link;
  sig_t sig, pat;

  assign shift_ev = scan_en;
  assign step_ev  = run_en & ~scan_en;

  // marks that the last rising edge was a test step
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) step_q <= 1'b0;
    else        step_q <= step_ev;
  end

  bsig_in_side #(.TAPS(TAPS)) in_i (
    .tck(tck), .rst_n(rst_n), .shift_ev(shift_ev), .step_ev(step_ev),
    .ser_in(tdi), .pins(pin_in), .sig(sig), .ser_out(link));

  bsig_out_side #(.TAPS(TAPS)) out_i (
    .tck(tck), .rst_n(rst_n), .shift_ev(shift_ev), .step_ev(step_ev),
    .mode(mode), .ser_in(link), .pat(pat), .ser_out(tdo));

  bsig_shadow in_sh_i  (.tck(tck), .rst_n(rst_n), .load(step_q), .d(sig), .q(core_out));
  bsig_shadow out_sh_i (.tck(tck), .rst_n(rst_n), .load(step_q), .d(pat), .q(pin_out));

  // R2: chain advances by one toward tdo
  a_r2_chain: assert property (@(posedge tck) disable iff (!rst_n)
    shift_ev |=> tdo == $past(pat[1]));
  // R2: scan leaves shadows alone
  a_r2_shadow_frozen: assert property (@(posedge tck) disable iff (!rst_n)
    $past(shift_ev) |-> !step_q);
  // R4: after a step the input shadow tracks the signature by the next rising edge
  a_r4_core_follows: assert property (@(posedge tck) disable iff (!rst_n)
    step_q |-> core_out == sig);
endmodule

// File: tb/bsig_engine_tb_top.sv
`timescale 1ns/100ps
module bsig_engine_tb_top;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0, tdi = 1'b0, run_en = 1'b0, mode = 1'b0;
  logic [7:0] pin_in = 8'h00;
  logic       tdo;
  logic [7:0] core_out, pin_out;

  int checks = 0, fails = 0;
  logic [7:0] m_in = 8'h00, m_out = 8'h00, m_core = 8'h00, m_pin = 8'h00;

  typedef struct packed { logic [7:0] core; logic [7:0] pin; } exp_t;
  exp_t       sb_q[$];
  string      sb_tag[$];

  always #2.5 tck = ~tck;   // 200 MHz

  bsig_engine dut_i (.tck(tck), .rst_n(rst_n), .scan_en(scan_en), .tdi(tdi),
    .run_en(run_en), .mode(mode), .pin_in(pin_in), .tdo(tdo),
    .core_out(core_out), .pin_out(pin_out));

  function automatic logic [7:0] f_gen(input logic [7:0] s);
    logic fb;
    fb = s[7] ^ s[5] ^ s[4] ^ s[3];
    return {s[6:0], fb};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // monitor: compares shadows just after each falling edge
  initial begin
    forever begin
      @(negedge tck);
      #0.5;
      if (sb_q.size() > 0) begin
        exp_t e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        chk({t, " core_out"}, {8'h00, core_out}, {8'h00, e.core});
        chk({t, " pin_out"},  {8'h00, pin_out},  {8'h00, e.pin});
      end
    end
  end

  // driver: one test step, expectation pushed after the rising edge
  task automatic do_step(input logic [7:0] pins, input logic md, input string tag);
    @(negedge tck); #1;
    scan_en = 1'b0; run_en = 1'b1; mode = md; pin_in = pins;
    m_in  = f_gen(m_in) ^ pins;
    m_out = md ? m_out + 8'd1 : f_gen(m_out);
    m_core = m_in; m_pin = m_out;
    @(posedge tck); #1;
    sb_q.push_back({m_core, m_pin});
    sb_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      run_en = 1'b0; scan_en = 1'b0;
    end
  endtask

  // 16-bit scan; chain bit j of {in,out} is shifted in j-th; tdo checked each shift
  task automatic scan16(input logic [7:0] new_in, input logic [7:0] new_out,
                        input logic keep_run, input string tag);
    logic [15:0] chain, load_v;
    chain = {m_in, m_out};
    load_v = {new_in, new_out};
    for (int j = 0; j < 16; j++) begin
      @(negedge tck); #1;
      scan_en = 1'b1; run_en = keep_run; tdi = load_v[j];
      chk({tag, " R2 tdo"}, {15'd0, tdo}, {15'd0, chain[0]});
      @(posedge tck);
      chain = {load_v[j], chain[15:1]};
    end
    @(negedge tck); #1;
    scan_en = 1'b0; run_en = 1'b0;
    m_in = chain[15:8]; m_out = chain[7:0];
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #7;
    // R1 reset state
    chk("R1 reset tdo/core", {7'd0, tdo, core_out}, 16'h0000);
    chk("R1 reset pin_out", {8'h00, pin_out}, 16'h0000);
    @(negedge tck); #1 rst_n = 1'b1;

    // R2 seed the chain
    scan16(8'h5A, 8'h01, 1'b0, "seed1");
    chk("R2 shadows frozen by scan", {core_out, pin_out}, 16'h0000);

    // R3 R4 R5 compaction plus pseudo-random
    do_step(8'h00, 1'b0, "R3 R5 step a");
    do_step(8'hFF, 1'b0, "R3 R5 step b");
    do_step(8'h3C, 1'b0, "R3 R5 step c");
    do_step(8'h81, 1'b0, "R4 R5 step d");
    do_step(8'hA5, 1'b0, "R4 R7 step e");
    idle(1);

    // R9 hold while idle
    idle(4);
    #0.5;
    chk("R9 hold core/pin", {core_out, pin_out}, {m_core, m_pin});

    // R2 scan with run_en high: scan wins, read back and reseed
    scan16(8'h00, 8'hFE, 1'b1, "R2 priority readback");
    chk("R2 R7 shadows kept after scan", {core_out, pin_out}, {m_core, m_pin});

    // R6 count mode with wrap
    do_step(8'h11, 1'b1, "R6 count ff");
    do_step(8'h22, 1'b1, "R6 wrap 00");
    do_step(8'h44, 1'b1, "R6 count 01");
    idle(2);

    // R8 zero seed stays at zero
    scan16(8'hC3, 8'h00, 1'b0, "R8 reseed");
    do_step(8'h07, 1'b0, "R8 zero a");
    do_step(8'h70, 1'b0, "R8 zero b");
    do_step(8'h00, 1'b0, "R8 zero c");
    idle(2);

    // final read-back of registers through the chain (R3 signature)
    scan16(8'h00, 8'h00, 1'b0, "R3 final signature");
    idle(2);
    #0.5;
    chk("R9 R7 final shadows", {core_out, pin_out}, {m_core, m_pin});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule